// File: doc/BRIEF.md
# Strap-Configured Shared Address/GPIO Pin Controller

This block owns three package pins that a memory controller shares between the upper DRAM address bits and a small set of general purpose IO lines. At reset release a 2-bit memory-type code is taken from the data bus. From then until the next reset that code decides which pins carry the address bits supplied on `dram_addr_i` and which ones act as GPIO. Whatever the code, the pin roles cannot change until reset is asserted again.

Software reaches the GPIOs through a direction register and a data register, using a single-cycle write strobe and a combinational read port. For each pin the block produces an output value, an output enable and a synchronized sample of the input pad. A pin that is claimed as an address line always drives its address bit, whatever the GPIO registers hold. A GPIO set as input is never driven, and a read of its data bit returns the pad level after it has passed through a two-flop synchronizer.

Top module: `shared_pin_ctrl`

## Requirements
- R1: The memory-type code is the value on `strap_i` at the last clock edge with `rst_n` low. After release it stays fixed until the next reset, whatever `strap_i` does.
- R2: With code 00, pin 0 is GPIO3, pin 1 is GPIO1 and pin 2 is GPIO2.
- R3: With code 01 or code 10, pin 0 drives address bit 0 with its enable high, pin 1 is GPIO1 and pin 2 is GPIO2.
- R4: With code 11, all three pins drive `dram_addr_i` with their enables high, and no GPIO exists.
- R5: The direction register is at offset 0x1E. Bits 3, 2 and 1 set GPIO3, GPIO2 and GPIO1, with 1 meaning output. A read returns those three bits in place, and bits 7..4 and bit 0 read as 0.
- R6: The data register is at offset 0x20, using the same bit positions as the direction register. When a GPIO is an output, its pin has the enable high and drives the written bit.
- R7: When a GPIO is an input, its pin enable is low. A read of its data bit returns the pad level, two clock edges after the pad changes.
- R8: The direction and data registers have no effect on a pin claimed as an address line.
- R9: Offset 0x1F is reserved. Writes there change nothing, and reads of it or of any other unmapped offset return 0.
- R10: A read of an output GPIO's data bit returns the last value written to it. Data bits of GPIOs that the current code does not provide read as 0.
- R11: Reset clears the direction register and the data register, so every GPIO starts as an undriven input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the memory-type code is captured while it is low |
| strap_i | input | 2 | Data bus bits 7..6, read as the memory-type code |
| reg_addr_i | input | 8 | Register offset for reads and writes |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 3 | Data bus bits 3..1 of a write |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| dram_addr_i | input | 3 | Address bits for pins 0, 1 and 2 |
| pin_in_i | input | 3 | Pad input levels, asynchronous |
| pin_out_o | output | 3 | Pad output values |
| pin_oe_o | output | 3 | Pad output enables, 1 = drive |

## Verification
The assertions assume that `strap_i` can only affect the pins through the reset window, and that `reg_addr_i` is a stable value in the clock domain whenever a read is observed. The stimulus changes the code bus only by holding it during reset and then moving it to a different value once reset is released. All register traffic and pad changes are driven on the falling edge. Random writes go to the two live offsets and to the reserved one. A fresh reset with a random code happens at intervals, so every mapping is covered together with random direction and data contents.

// File: rtl/spc_pkg.sv
// Package for the shared pin controller: counts, the memory-type
// code and the per-pin role decode.
// Assumes pins are numbered 0..2 from the lowest shared address bit.
package spc_pkg;

    localparam int NUM_PINS = 3;
    localparam int NUM_GPIO = 3;
    localparam int CODE_W   = 2;
    localparam int IDX_W    = $clog2(NUM_GPIO + 1);

    typedef enum logic [CODE_W-1:0] {
        MT_ALL_GPIO = 2'b00,
        MT_MIX_A    = 2'b01,
        MT_MIX_B    = 2'b10,
        MT_ALL_ADDR = 2'b11
    } memtype_e;

    typedef struct packed {
        logic             is_gpio;
        logic [IDX_W-1:0] gpio_num;   // 1..NUM_GPIO when is_gpio
    } pin_role_t;

    // Role of one pin under a given memory-type code
    function automatic pin_role_t role_of(memtype_e mt, int unsigned pin);
        pin_role_t r;
        r = '{is_gpio: 1'b0, gpio_num: '0};
        unique case (mt)
            MT_ALL_GPIO: begin
                r.is_gpio = 1'b1;
                case (pin)
                    0:       r.gpio_num = IDX_W'(3);
                    1:       r.gpio_num = IDX_W'(1);
                    default: r.gpio_num = IDX_W'(2);
                endcase
            end
            MT_MIX_A, MT_MIX_B: begin
                if (pin != 0) begin
                    r.is_gpio  = 1'b1;
                    r.gpio_num = (pin == 1) ? IDX_W'(1) : IDX_W'(2);
                end
            end
            default: r = '{is_gpio: 1'b0, gpio_num: '0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spc_strap.sv
// Memory-type strap capture.
// Reloads the code every clock while reset is held and freezes it once
// reset is released, so the code in force is the one present at release.
// Assumes the strap bus is stable around the release edge.
module spc_strap
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] strap_i,
    output memtype_e          code_o
);

    memtype_e code_q;

    // Track the strap during reset, hold it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= memtype_e'(strap_i);
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/spc_regs.sv
// GPIO direction and data registers with readback.
// Assumes one write per strobe cycle. Reads are combinational on the offset.
// Unmapped and reserved offsets read zero.
module spc_regs
    import spc_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] CFG_OFS = 8'h1E,
    parameter logic [ADDR_W-1:0] RSV_OFS = 8'h1F,
    parameter logic [ADDR_W-1:0] CTL_OFS = 8'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_i,
    input  logic [NUM_GPIO:1]   wdata_i,
    input  logic [NUM_GPIO:1]   avail_i,
    input  logic [NUM_GPIO:1]   level_i,
    output logic [NUM_GPIO:1]   dir_o,
    output logic [NUM_GPIO:1]   data_o,
    output logic [DATA_W-1:0]   rdata_o
);

    localparam int HI_PAD = DATA_W - NUM_GPIO - 1;

    logic [NUM_GPIO:1] dir_q;
    logic [NUM_GPIO:1] data_q;
    logic [NUM_GPIO:1] ctl_view;

    // Direction register: cleared on reset, loaded by writes to its offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_i && addr_i == CFG_OFS) begin
            dir_q <= wdata_i;
        end
    end

    // Data register: cleared on reset, loaded by writes to its offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_i && addr_i == CTL_OFS) begin
            data_q <= wdata_i;
        end
    end

    // Data/status view: written value for outputs, pad level for inputs
    always_comb begin
        for (int g = 1; g <= NUM_GPIO; g++) begin
            if (!avail_i[g])
                ctl_view[g] = 1'b0;
            else if (dir_q[g])
                ctl_view[g] = data_q[g];
            else
                ctl_view[g] = level_i[g];
        end
    end

    // Read multiplexer; the reserved offset falls to zero
    always_comb begin
        unique case (addr_i)
            CFG_OFS: rdata_o = {{HI_PAD{1'b0}}, dir_q, 1'b0};
            CTL_OFS: rdata_o = {{HI_PAD{1'b0}}, ctl_view, 1'b0};
            RSV_OFS: rdata_o = '0;
            default: rdata_o = '0;
        endcase
    end

    assign dir_o  = dir_q;
    assign data_o = data_q;

endmodule

// File: rtl/spc_pin_mux.sv
// Per-pin function multiplexer and input synchronizers.
// Address pins always drive their address bit. GPIO pins follow the
// direction and data registers. Every pad input passes two flops before
// it is reported back per GPIO number.
// Assumes the code is constant outside reset.
module spc_pin_mux
    import spc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  memtype_e            code_i,
    input  logic [NUM_GPIO:1]   dir_i,
    input  logic [NUM_GPIO:1]   data_i,
    input  logic [NUM_PINS-1:0] addr_i,
    input  logic [NUM_PINS-1:0] pin_in_i,
    output logic [NUM_PINS-1:0] pin_out_o,
    output logic [NUM_PINS-1:0] pin_oe_o,
    output logic [NUM_GPIO:1]   avail_o,
    output logic [NUM_GPIO:1]   level_o
);

    logic [NUM_PINS-1:0] sync1_q;
    logic [NUM_PINS-1:0] sync2_q;
    pin_role_t           role [NUM_PINS];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // Two-flop synchronizer for this pad
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync1_q[p] <= 1'b0;
                sync2_q[p] <= 1'b0;
            end else begin
                sync1_q[p] <= pin_in_i[p];
                sync2_q[p] <= sync1_q[p];
            end
        end

        // Role decode and pad drive for this pin
        always_comb begin
            role[p] = role_of(code_i, p);
            if (role[p].is_gpio) begin
                pin_out_o[p] = data_i[role[p].gpio_num];
                pin_oe_o[p]  = dir_i[role[p].gpio_num];
            end else begin
                pin_out_o[p] = addr_i[p];
                pin_oe_o[p]  = 1'b1;
            end
        end
    end

    // Gather availability and synchronized level by GPIO number
    always_comb begin
        avail_o = '0;
        level_o = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (role[p].is_gpio) begin
                avail_o[role[p].gpio_num] = 1'b1;
                level_o[role[p].gpio_num] = sync2_q[p];
            end
        end
    end

endmodule

// File: rtl/shared_pin_ctrl.sv
// Top of the shared address/GPIO pin controller.
// Captures the memory-type code at reset release, holds the GPIO
// registers and drives the three shared pads.
// Assumes a single clock domain for the register port. Pad inputs are asynchronous.
module shared_pin_ctrl
    import spc_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] CFG_OFS = 8'h1E,
    parameter logic [ADDR_W-1:0] RSV_OFS = 8'h1F,
    parameter logic [ADDR_W-1:0] CTL_OFS = 8'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   strap_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic                reg_wr_i,
    input  logic [NUM_GPIO-1:0] reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    input  logic [NUM_PINS-1:0] dram_addr_i,
    input  logic [NUM_PINS-1:0] pin_in_i,
    output logic [NUM_PINS-1:0] pin_out_o,
    output logic [NUM_PINS-1:0] pin_oe_o
);

    memtype_e          strap_q;
    logic [NUM_GPIO:1] dir_q;
    logic [NUM_GPIO:1] data_q;
    logic [NUM_GPIO:1] gpio_avail;
    logic [NUM_GPIO:1] gpio_level;

    spc_strap u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_i),
        .code_o  (strap_q)
    );

    spc_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CFG_OFS (CFG_OFS),
        .RSV_OFS (RSV_OFS),
        .CTL_OFS (CTL_OFS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .avail_i (gpio_avail),
        .level_i (gpio_level),
        .dir_o   (dir_q),
        .data_o  (data_q),
        .rdata_o (reg_rdata_o)
    );

    spc_pin_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_i    (strap_q),
        .dir_i     (dir_q),
        .data_i    (data_q),
        .addr_i    (dram_addr_i),
        .pin_in_i  (pin_in_i),
        .pin_out_o (pin_out_o),
        .pin_oe_o  (pin_oe_o),
        .avail_o   (gpio_avail),
        .level_o   (gpio_level)
    );

endmodule

// File: rtl/shared_pin_ctrl_chk.sv
// Property checker for the shared pin controller, bound to the top.
// Watches the captured code, the direction register and the pad outputs.
module shared_pin_ctrl_chk
    import spc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input memtype_e            code,
    input logic [NUM_GPIO:1]   dir,
    input logic [7:0]          addr,
    input logic [7:0]          rdata,
    input logic [NUM_PINS-1:0] dram_addr,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);

    // R1
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(code));

    // R4
    all_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code == MT_ALL_ADDR |-> (pin_oe == 3'b111 && pin_out == dram_addr));

    // R3
    mix_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == MT_MIX_A || code == MT_MIX_B) |-> (pin_oe[0] && pin_out[0] == dram_addr[0]));

    // R7
    gpio_in_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code != MT_ALL_ADDR && !dir[1]) |-> !pin_oe[1]);

    // R9
    rsv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr == 8'h1F |-> rdata == 8'h00);

    // R5
    cfg_pad_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr == 8'h1E |-> (rdata[7:4] == 4'h0 && !rdata[0]));

endmodule

bind shared_pin_ctrl shared_pin_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (strap_q),
    .dir       (dir_q),
    .addr      (reg_addr_i),
    .rdata     (reg_rdata_o),
    .dram_addr (dram_addr_i),
    .pin_out   (pin_out_o),
    .pin_oe    (pin_oe_o)
);

// File: tb/shared_pin_ctrl_test.sv
module shared_pin_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] CFG = 8'h1E, RSV = 8'h1F, CTL = 8'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap = 2'b00;
    logic [7:0] addr = 8'h00;
    logic       wr = 1'b0;
    logic [2:0] wdata = 3'b000;
    logic [7:0] rdata;
    logic [2:0] dram_a = 3'b000;
    logic [2:0] pin_in = 3'b000;
    logic [2:0] pin_out;
    logic [2:0] pin_oe;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    logic [1:0] m_code;
    logic [3:1] m_dir, m_data;
    logic [2:0] m_pin;

    shared_pin_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (strap),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .dram_addr_i (dram_a),
        .pin_in_i    (pin_in),
        .pin_out_o   (pin_out),
        .pin_oe_o    (pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // GPIO number on a pin for a code; 0 means address line
    function automatic int gnum(logic [1:0] c, int p);
        if (c == 2'b11) return 0;
        if (c == 2'b00) return (p == 0) ? 3 : (p == 1) ? 1 : 2;
        return (p == 0) ? 0 : (p == 1) ? 1 : 2;
    endfunction

    function automatic logic [2:0] exp_oe();
        logic [2:0] r;
        for (int p = 0; p < 3; p++)
            r[p] = (gnum(m_code, p) == 0) ? 1'b1 : m_dir[gnum(m_code, p)];
        return r;
    endfunction

    function automatic logic [2:0] exp_out();
        logic [2:0] r;
        for (int p = 0; p < 3; p++)
            r[p] = (gnum(m_code, p) == 0) ? dram_a[p] : m_data[gnum(m_code, p)];
        return r;
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        logic [3:1] v;
        if (a == CFG) return {4'h0, m_dir, 1'b0};
        if (a != CTL) return 8'h00;
        v = '0;
        for (int p = 0; p < 3; p++)
            if (gnum(m_code, p) != 0)
                v[gnum(m_code, p)] = m_dir[gnum(m_code, p)] ? m_data[gnum(m_code, p)] : m_pin[p];
        return v == 3'b000 ? 8'h00 : {4'h0, v, 1'b0};
    endfunction

    function automatic string map_req();
        if (m_code == 2'b00) return "R2";
        if (m_code == 2'b11) return "R4";
        return "R3";
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(logic [7:0] a, logic [2:0] d);
        addr = a; wr = 1'b1; wdata = d;
        tick();
        wr = 1'b0;
        if (a == CFG) m_dir = d;
        if (a == CTL) m_data = d;
    endtask

    task automatic read_chk(logic [7:0] a, string req);
        addr = a;
        #1;
        check(req, rdata, exp_rd(a));
    endtask

    task automatic pins_chk(string req);
        #1;
        check({req, " oe"}, {5'b0, pin_oe}, {5'b0, exp_oe()});
        check({req, " out"}, {5'b0, pin_out & exp_oe()}, {5'b0, exp_out() & exp_oe()});
    endtask

    task automatic set_pins(logic [2:0] v);
        pin_in = v;
        tick();
        tick();
        m_pin = v;
    endtask

    task automatic do_reset(logic [1:0] c);
        rst_n = 1'b0; strap = c; wr = 1'b0; pin_in = 3'b000;
        tick(); tick(); tick();
        rst_n = 1'b1;
        m_code = c; m_dir = '0; m_data = '0; m_pin = '0;
        strap = ~c;   // R1: later strap changes must not matter
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        @(negedge clk);
        // Directed pass over every code
        for (int c = 0; c < 4; c++) begin
            do_reset(2'(c));
            read_chk(CFG, "R11");
            read_chk(CTL, "R11");
            check("R11 oe", {5'b0, pin_oe}, {5'b0, exp_oe()});
            dram_a = 3'b101;
            pins_chk({map_req(), " R1"});
            read_chk(RSV, "R9");
            reg_write(CFG, 3'b111);
            read_chk(CFG, "R5");
            reg_write(CTL, 3'b010);
            pins_chk("R6 R8");
            read_chk(CTL, "R10");
            reg_write(RSV, 3'b101);
            read_chk(CFG, "R9");
            read_chk(CTL, "R9");
            read_chk(RSV, "R9");
            reg_write(CFG, 3'b000);
            set_pins(3'b111);
            pins_chk("R7");
            read_chk(CTL, "R7");
            set_pins(3'b010);
            read_chk(CTL, "R7");
            dram_a = 3'b010;
            reg_write(CFG, 3'b111);
            pins_chk({map_req(), " R8"});
        end
        // Random traffic with occasional resets
        for (int i = 0; i < 600; i++) begin
            int op;
            if (i % 75 == 0) do_reset(2'($urandom_range(0, 3)));
            op = $urandom_range(0, 9);
            dram_a = 3'($urandom);
            if (op < 4)      reg_write(CFG, 3'($urandom));
            else if (op < 7) reg_write(CTL, 3'($urandom));
            else if (op < 8) reg_write(RSV, 3'($urandom));
            else             set_pins(3'($urandom));
            pins_chk(map_req());
            read_chk(CFG, "R5");
            read_chk(CTL, "R10");
            read_chk(8'($urandom), "R9");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule